// File: doc/BRIEF.md
# Delta-Sigma Converter Serial Readout Controller

This block is the device-side digital controller of a single-channel converter that only sends data. It runs a repeating cycle of three phases: a conversion, an idle hold with the finished result, and a serial shift-out. A timer of fixed length stands in for the converter core. When the timer expires, the block captures the 16-bit word on `conv_result` and holds it until a host reads it.

The host drives only a chip select and a serial clock. Both pins are brought into the system clock domain through a two-stage synchronizer before any edge is detected. With chip select low, the data line first acts as a status flag: high means a conversion is running, low means a result is waiting. During readout, the data line carries the result MSB first, and each bit changes on a serial-clock falling edge so that the host can sample it on the rising edge.

A new conversion starts in one of two ways. The host can raise chip select, which also aborts any transfer still in progress. Or the host can give one more serial-clock falling edge after the last bit. This works both with a clock that idles low and with one that idles high.

Top module: `dss_serial_port`

## Requirements
- R1: Reset starts a conversion. `spi_miso_oe` is low whenever chip select is high, and high whenever it is low.
- R2: During a conversion with chip select low, `spi_miso` is 1. A chip-select falling edge in this phase does not begin readout.
- R3: A conversion lasts `CONV_CYCLES` system clocks. The block then waits with the result, and with chip select low `spi_miso` is 0.
- R4: The result word is captured when the conversion ends. Later changes on `conv_result` do not alter the word that is read.
- R5: A chip-select falling edge while waiting, with the serial clock low, puts bit 15 on `spi_miso`. Each following serial-clock falling edge presents the next lower bit.
- R6: A chip-select falling edge while waiting, with the serial clock high, keeps the ready flag (0) on `spi_miso`. The first serial-clock falling edge then presents bit 15.
- R7: The serial-clock falling edge that follows the edge presenting bit 0 starts a new conversion. A later chip-select rise in that conversion has no effect.
- R8: A chip-select rising edge at any point in readout drops the unsent bits and starts a new conversion.
- R9: Serial-clock edges while converting, and while chip select is high, neither shift nor start anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spi_cs_n | input | 1 | Chip select from the host, active low, asynchronous |
| spi_sck | input | 1 | Serial clock from the host, asynchronous |
| conv_result | input | 16 | Result word from the converter core, captured at conversion end |
| spi_miso | output | 1 | Serial data and status line |
| spi_miso_oe | output | 1 | Output enable for `spi_miso`; low means high impedance |

## Verification
The hardest cases to reach from the ports are the two ways of entering readout when the host is polling for status. If the serial clock is high when chip select falls, the data line must keep showing the ready flag and not bit 15. In that case the start of the next conversion moves to the seventeenth falling edge. The stimulus reaches this by choosing result words whose bit 15 is 1 and bit 14 is 0, so that a flag, a bit and a shifted bit each give a different value. It then parks the clock high before lowering chip select, and counts edges on both clock polarities. The same word choice shows that clock pulses sent while chip select is high shift nothing.

// File: rtl/dss_pkg.sv
package dss_pkg;

  typedef enum logic [1:0] {
    ST_CONVERT = 2'd0,
    ST_SLEEP   = 2'd1,
    ST_OUTPUT  = 2'd2
  } dss_state_e;

  // level on the data line for a phase: busy high, ready low, data bit in readout
  function automatic logic line_level(input dss_state_e st, input logic msb);
    case (st)
      ST_CONVERT: line_level = 1'b1;
      ST_SLEEP:   line_level = 1'b0;
      ST_OUTPUT:  line_level = msb;
      default:    line_level = 1'b0;
    endcase
  endfunction

  // true when a synchronized level moved from high to low
  function automatic logic went_low(input logic prev, input logic now);
    went_low = prev & ~now;
  endfunction

  // true when a synchronized level moved from low to high
  function automatic logic went_high(input logic prev, input logic now);
    went_high = ~prev & now;
  endfunction

endpackage

// File: rtl/dss_edge_sync.sv
module dss_edge_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic level_o,
  output logic prev_o
);
  logic [STAGES-1:0] chain;
  logic              prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain  <= {STAGES{RESET_VAL}};
      prev_q <= RESET_VAL;
    end else begin
      chain  <= {chain[STAGES-2:0], pin_i};
      prev_q <= chain[STAGES-1];
    end
  end

  assign level_o = chain[STAGES-1];
  assign prev_o  = prev_q;
endmodule

// File: rtl/dss_conv_timer.sv
module dss_conv_timer #(
  parameter int CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic done_o
);
  localparam int CNT_W = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt;
  logic             running;

  assign done_o = running && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b1;
      cnt     <= '0;
    end else if (start_i) begin
      running <= 1'b1;
      cnt     <= '0;
    end else if (running) begin
      if (done_o) running <= 1'b0;
      else        cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/dss_shifter.sv
module dss_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         shift_i,
  input  logic         clear_i,
  output logic         msb_o
);
  logic [W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       word_q <= '0;
    else if (load_i)  word_q <= data_i;
    else if (clear_i) word_q <= '0;
    else if (shift_i) word_q <= {word_q[W-2:0], 1'b0};
  end

  assign msb_o = word_q[W-1];
endmodule

// File: rtl/dss_serial_port.sv
module dss_serial_port
  import dss_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CONV_CYCLES = 200,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic [DATA_W-1:0] conv_result,
  output logic              spi_miso,
  output logic              spi_miso_oe
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(DATA_W - 1);

  // synchronized pins and their edges
  logic cs_level, cs_prev, sck_level, sck_prev;
  logic cs_rise, cs_fall, sck_fall;

  dss_edge_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(spi_cs_n),
    .level_o(cs_level), .prev_o(cs_prev)
  );

  dss_edge_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(spi_sck),
    .level_o(sck_level), .prev_o(sck_prev)
  );

  assign cs_rise  = went_high(cs_prev, cs_level);
  assign cs_fall  = went_low(cs_prev, cs_level);
  assign sck_fall = went_low(sck_prev, sck_level);

  // phase machine
  dss_state_e       state, state_nxt;
  logic [BIT_W-1:0] bit_idx, bit_idx_nxt;
  logic             conv_start, conv_done;
  logic             word_load, word_shift, word_clear, word_msb;

  always_comb begin
    state_nxt   = state;
    bit_idx_nxt = bit_idx;
    conv_start  = 1'b0;
    word_load   = 1'b0;
    word_shift  = 1'b0;
    word_clear  = 1'b0;
    case (state)
      ST_CONVERT: begin
        if (conv_done) begin
          state_nxt = ST_SLEEP;
          word_load = 1'b1;
        end
      end
      ST_SLEEP: begin
        if (!cs_level && ((cs_fall && !sck_level) || sck_fall)) begin
          state_nxt   = ST_OUTPUT;
          bit_idx_nxt = '0;
        end
      end
      ST_OUTPUT: begin
        if (cs_rise) begin
          state_nxt  = ST_CONVERT;
          conv_start = 1'b1;
          word_clear = 1'b1;
        end else if (sck_fall) begin
          if (bit_idx == LAST_IDX) begin
            state_nxt  = ST_CONVERT;
            conv_start = 1'b1;
          end else begin
            word_shift  = 1'b1;
            bit_idx_nxt = bit_idx + 1'b1;
          end
        end
      end
      default: state_nxt = ST_CONVERT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_CONVERT;
      bit_idx <= '0;
    end else begin
      state   <= state_nxt;
      bit_idx <= bit_idx_nxt;
    end
  end

  dss_conv_timer #(.CYCLES(CONV_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(conv_start), .done_o(conv_done)
  );

  dss_shifter #(.W(DATA_W)) u_word (
    .clk(clk), .rst_n(rst_n), .load_i(word_load), .data_i(conv_result),
    .shift_i(word_shift), .clear_i(word_clear), .msb_o(word_msb)
  );

  assign spi_miso    = line_level(state, word_msb);
  assign spi_miso_oe = ~cs_level;
endmodule

// File: rtl/dss_serial_port_chk.sv
module dss_serial_port_chk
  import dss_pkg::*;
#(
  parameter int BIT_W  = 4,
  parameter int DATA_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input dss_state_e       state,
  input logic [BIT_W-1:0] bit_idx,
  input logic             conv_done,
  input logic             cs_rise,
  input logic             sck_fall,
  input logic             spi_miso,
  input logic             spi_miso_oe
);
  localparam logic [BIT_W-1:0] LAST_IDX = BIT_W'(DATA_W - 1);

  a_r2_stay_convert: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONVERT && !conv_done) |=> state == ST_CONVERT);

  a_r2_busy_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONVERT && spi_miso_oe) |-> spi_miso);

  a_r3_done_to_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_CONVERT && conv_done) |=> state == ST_SLEEP);

  a_r3_ready_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP && spi_miso_oe) |-> !spi_miso);

  a_r4_sleep_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SLEEP) |=> state != ST_CONVERT);

  a_r5_step: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OUTPUT && !cs_rise && sck_fall && bit_idx != LAST_IDX)
      |=> (state == ST_OUTPUT && bit_idx == BIT_W'($past(bit_idx) + 1'b1)));

  a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OUTPUT && !cs_rise && sck_fall && bit_idx == LAST_IDX)
      |=> state == ST_CONVERT);

  a_r8_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OUTPUT && cs_rise) |=> state == ST_CONVERT);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_OUTPUT && !cs_rise && !sck_fall)
      |=> (state == ST_OUTPUT && $stable(bit_idx)));
endmodule

bind dss_serial_port dss_serial_port_chk #(.BIT_W(BIT_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .bit_idx(bit_idx),
  .conv_done(conv_done), .cs_rise(cs_rise), .sck_fall(sck_fall),
  .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe)
);

// File: tb/tb_dss_serial_port.sv
module tb_dss_serial_port;
  localparam int CONV_CYC = 200;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1;
  logic        sck = 1'b0;
  logic [15:0] result = 16'hA5C3;
  logic        miso, miso_oe;

  always #4 clk = ~clk;

  dss_serial_port #(.DATA_W(16), .CONV_CYCLES(CONV_CYC), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck),
    .conv_result(result), .spi_miso(miso), .spi_miso_oe(miso_oe)
  );

  typedef struct {
    logic sdo;
    logic oe;
    int   req;
  } exp_t;

  exp_t q[$];
  event chk_ev;
  int   n_run = 0;
  int   n_fail = 0;
  bit   done = 0;

  // monitor: pops expected items and compares them against the pins
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_run++;
        if (miso_oe !== e.oe || (e.oe && miso !== e.sdo)) begin
          n_fail++;
          $display("FAIL R%0d: sdo=%b oe=%b expected sdo=%b oe=%b",
                   e.req, miso, miso_oe, e.sdo, e.oe);
        end
      end
    end
  end

  task automatic settle();
    repeat (6) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_cs(input logic v);
    @(negedge clk) cs_n = v;
    settle();
  endtask

  task automatic set_sck(input logic v);
    @(negedge clk) sck = v;
    settle();
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_pin(input logic s, input logic oe, input int r);
    exp_t e;
    e.sdo = s; e.oe = oe; e.req = r;
    q.push_back(e);
    -> chk_ev;
    #1;
  endtask

  localparam logic [15:0] W_A = 16'hA5C3;
  localparam logic [15:0] W_B = 16'h9E27;
  localparam logic [15:0] W_C = 16'hEB5D;

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    settle();

    expect_pin(1'b0, 1'b0, 1);                    // R1 tri-state with CS high
    set_cs(1'b0);
    expect_pin(1'b1, 1'b1, 2);                    // R2 busy, CS fall ignored
    set_sck(1'b1); set_sck(1'b0);
    expect_pin(1'b1, 1'b1, 9);                    // R9 SCK in conversion ignored
    idle(CONV_CYC + 10);
    expect_pin(1'b0, 1'b1, 3);                    // R3 ready flag
    result = W_B;                                 // R4 change after capture
    set_sck(1'b1);
    expect_pin(1'b0, 1'b1, 6);                    // R6 rising edge alone does nothing
    for (int i = 0; i < 16; i++) begin
      set_sck(1'b0);
      expect_pin(W_A[15-i], 1'b1, (i == 0) ? 6 : 4); // R4 R6 old word MSB first
      set_sck(1'b1);
    end
    set_sck(1'b0);
    expect_pin(1'b1, 1'b1, 7);                    // R7 17th fall starts conversion
    set_sck(1'b1);
    set_cs(1'b1);
    expect_pin(1'b0, 1'b0, 1);                    // R1

    // idle-high poll, then abort mid-word
    idle(CONV_CYC + 10);
    set_cs(1'b0);
    expect_pin(1'b0, 1'b1, 6);                    // R6 ready flag, not D15
    set_sck(1'b0);
    expect_pin(W_B[15], 1'b1, 6);                 // R6 first fall shows D15
    set_sck(1'b1); set_sck(1'b0);
    expect_pin(W_B[14], 1'b1, 5);                 // R5
    set_sck(1'b1); set_sck(1'b0);
    expect_pin(W_B[13], 1'b1, 5);                 // R5
    result = W_C;
    set_cs(1'b1);                                 // R8 abort
    set_cs(1'b0);
    expect_pin(1'b1, 1'b1, 8);                    // R8 new conversion running
    idle(CONV_CYC - 40);
    expect_pin(1'b1, 1'b1, 3);                    // R3 still converting
    idle(50);
    expect_pin(1'b0, 1'b1, 3);                    // R3 finished after CONV_CYCLES

    // idle-low read, 16th fall restarts
    set_cs(1'b1);
    set_cs(1'b0);
    expect_pin(W_C[15], 1'b1, 5);                 // R5 CS fall shows D15, unsent bits gone
    for (int i = 1; i < 16; i++) begin
      set_sck(1'b1); set_sck(1'b0);
      expect_pin(W_C[15-i], 1'b1, 5);             // R5
    end
    set_sck(1'b1); set_sck(1'b0);
    expect_pin(1'b1, 1'b1, 7);                    // R7 16th fall starts conversion
    set_cs(1'b1); set_cs(1'b0);
    expect_pin(1'b1, 1'b1, 7);                    // R7 CS rise afterwards no effect

    // minimum length output: CS only
    idle(CONV_CYC + 10);
    result = W_A;
    set_cs(1'b1); set_cs(1'b0);
    expect_pin(W_C[15], 1'b1, 5);                 // R5
    set_cs(1'b1); set_cs(1'b0);
    expect_pin(1'b1, 1'b1, 8);                    // R8 restart without clocks

    // clocks with CS high shift nothing
    idle(CONV_CYC + 10);
    set_cs(1'b1);
    set_sck(1'b1); set_sck(1'b0);
    set_sck(1'b1); set_sck(1'b0);
    set_cs(1'b0);
    expect_pin(W_A[15], 1'b1, 9);                 // R9 still D15
    set_sck(1'b1); set_sck(1'b0);
    expect_pin(W_A[14], 1'b1, 9);                 // R9 then D14
    set_cs(1'b1);
    expect_pin(1'b0, 1'b0, 1);                    // R1

    idle(2);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL R0: watchdog expired, actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule